// File: doc/BRIEF.md
# Soft Mute Ramp Controller

This block mutes an audio sample stream without a click. It does not cut the signal in one step. It walks an attenuation code from unity gain down to a mute floor and back again. Each step takes a fixed number of clock cycles. A fast or a slow slope can be chosen, and the two differ by a factor of about 35. The code is applied to a signed sample stream. At the floor the output is forced to exactly zero.

A mute can be requested in two ways: by a control-register bit, or by an external pin that is active low and rests high when nothing drives it. The two requests are ORed together. While either one is held, the ramp runs down to the floor and stays there. When both are released, the ramp climbs back at the selected slope. A status output stays high from the moment a request is registered until unity gain is reached again.

Top module: `smute_ctrl`

## Requirements
- R1: While reset is held, `att_code` is 0, `mute_active` is 0 and `smp_out` is 0.
- R2: With `att_code` at 0, `smp_out` equals `smp_in` one clock later.
- R3: The mute request is `mute_req_bit` OR (NOT `mute_pin_n`). The bit is registered once, so it acts after 1 edge. The pin passes two synchronizer stages and then the request register, so it acts after 3 edges. Either source alone keeps the mute held.
- R4: While a request is held and the code is below the floor, the code rises by exactly 1 every DIV cycles. If the request register becomes 1 at edge P, the code reads k after edge P+k*DIV.
- R5: `slow_slope_sel`=0 selects the fast divider. `slow_slope_sel`=1 selects the slow divider. Each divider is clock ticks per µs × time to reach the 20 dB point / steps to that point. The default times are 1 ms and 35 ms.
- R6: At the floor code (default 40, which is 60 dB) the code holds while a request is held. `smp_out` is 0 for every input, including full-scale negative.
- R7: After both requests are released, the code falls by 1 every DIV cycles until it reaches 0, and then it stays at 0.
- R8: `mute_active` is high while the registered request is high or the code is non-zero. It drops in the cycle in which the code returns to 0.
- R9: The slope is sampled only while the ramp is idle or at a step boundary. A change of `slow_slope_sel` in the middle of a step leaves the current step's length unchanged and applies from the next step.
- R10: For a code k below the floor, let S = k/4 and j = k mod 4. M is round(256·2^(-j/4)), which gives 256, 215, 181 and 152 for j = 0 to 3. Then `smp_out` = (smp_in·M) >>> (8+S), an arithmetic shift, one clock later.
- R11: With `mute_pin_n` high (its resting level) and the bit low, no mute happens: the code stays 0 and `mute_active` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mute_req_bit | input | 1 | Mute request from the control register |
| slow_slope_sel | input | 1 | 0 = fast slope, 1 = slow slope |
| mute_pin_n | input | 1 | External mute request, active low, resting high |
| smp_in | input | SMP_W | Signed input sample |
| smp_out | output | SMP_W | Signed attenuated sample, registered |
| att_code | output | ATT_W | Current attenuation code, 0 = unity |
| mute_active | output | 1 | Soft mute active status |

## Verification
Each result has a fixed due cycle relative to its stimulus:
- An attenuated sample appears one edge after it is presented.
- Step k of a ramp lands 1+k·DIV edges after the request bit is written, or 3+k·DIV edges after the pin falls.
- The status flag follows the request register.

The driver turns every stimulus into queued expectations tagged with the absolute cycle at which they fall due. This includes the value one cycle before each step, so an early step is caught as well as a late one. The monitor compares each expectation only at its due cycle, sampling on the falling edge. Sample-gain checks are placed in the middle of long slow steps, so the code is stable across the compared edge.

// File: rtl/smute_pkg.sv
`timescale 1ns/1ps
package smute_pkg;

    typedef enum logic {
        SLOPE_FAST = 1'b0,
        SLOPE_SLOW = 1'b1
    } slope_e;

    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_DOWN = 2'd1,
        DIR_UP   = 2'd2
    } dir_e;

    localparam int GAIN_FRAC = 8;
    localparam int MANT_W    = GAIN_FRAC + 1;

    // Gain of one quarter of a 6 dB octave: round(256 * 2^(-j/4))
    function automatic logic [MANT_W-1:0] frac_gain(input logic [1:0] j);
        case (j)
            2'd0:    return MANT_W'(256);
            2'd1:    return MANT_W'(215);
            2'd2:    return MANT_W'(181);
            default: return MANT_W'(152);
        endcase
    endfunction

    // Clock cycles per attenuation step, never below one
    function automatic int step_div(input int tpu, input int time_us, input int steps);
        int d;
        d = (tpu * time_us) / steps;
        return (d < 1) ? 1 : d;
    endfunction

endpackage

// File: rtl/smute_req_sync.sv
`timescale 1ns/1ps
module smute_req_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic reg_req,
    input  logic pin_n,
    output logic req_o
);
    logic [SYNC_STAGES-1:0] pin_sync;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_sync <= '1;
            req_o    <= 1'b0;
        end else begin
            pin_sync <= {pin_sync[SYNC_STAGES-2:0], pin_n};
            req_o    <= reg_req | ~pin_sync[SYNC_STAGES-1];
        end
    end

    // R3
    reg_req_latency_chk: assert property (@(posedge clk) disable iff (rst)
        reg_req |=> req_o);

endmodule

// File: rtl/smute_ramp.sv
`timescale 1ns/1ps
module smute_ramp
    import smute_pkg::*;
#(
    parameter int FLOOR_CODE = 40,
    parameter int FAST_DIV   = 4,
    parameter int SLOW_DIV   = 140,
    parameter int ATT_W      = 6,
    parameter int CNT_W      = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_i,
    input  logic             slow_i,
    output logic [ATT_W-1:0] att_o
);
    localparam logic [ATT_W-1:0] FLOOR_C = ATT_W'(FLOOR_CODE);
    localparam logic [CNT_W-1:0] FAST_M1 = CNT_W'(FAST_DIV - 1);
    localparam logic [CNT_W-1:0] SLOW_M1 = CNT_W'(SLOW_DIV - 1);

    slope_e           slope_q;
    logic [CNT_W-1:0] cnt_q;
    logic [ATT_W-1:0] att_q;
    logic [CNT_W-1:0] div_m1;
    dir_e             dir;
    logic             step;

    always_comb begin
        if (req_i && (att_q != FLOOR_C))
            dir = DIR_DOWN;
        else if (!req_i && (att_q != '0))
            dir = DIR_UP;
        else
            dir = DIR_HOLD;
        div_m1 = (slope_q == SLOPE_SLOW) ? SLOW_M1 : FAST_M1;
        step   = (dir != DIR_HOLD) && (cnt_q == div_m1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            att_q   <= '0;
            cnt_q   <= '0;
            slope_q <= SLOPE_FAST;
        end else if (dir == DIR_HOLD) begin
            cnt_q   <= '0;
            slope_q <= slope_e'(slow_i);
        end else if (step) begin
            cnt_q   <= '0;
            slope_q <= slope_e'(slow_i);
            att_q   <= (dir == DIR_DOWN) ? att_q + ATT_W'(1) : att_q - ATT_W'(1);
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign att_o = att_q;

    // R6
    hold_floor_chk: assert property (@(posedge clk) disable iff (rst)
        (req_i && att_q == FLOOR_C) |=> (att_q == FLOOR_C));

    // R7
    idle_unity_chk: assert property (@(posedge clk) disable iff (rst)
        (!req_i && att_q == '0) |=> (att_q == '0));

    // R4
    unit_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(att_q) |-> ((att_q == $past(att_q) + ATT_W'(1)) ||
                             ($past(att_q) == att_q + ATT_W'(1))));

    // R9
    step_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(att_q) |-> ($past(cnt_q) == $past(div_m1)));

endmodule

// File: rtl/smute_gain.sv
`timescale 1ns/1ps
module smute_gain
    import smute_pkg::*;
#(
    parameter int SMP_W      = 16,
    parameter int ATT_W      = 6,
    parameter int FLOOR_CODE = 40
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ATT_W-1:0]        att_i,
    input  logic signed [SMP_W-1:0] smp_i,
    output logic signed [SMP_W-1:0] smp_o
);
    localparam int               PW      = SMP_W + MANT_W + 1;
    localparam logic [ATT_W-1:0] FLOOR_C = ATT_W'(FLOOR_CODE);

    logic signed [MANT_W:0] mant_s;
    logic signed [PW-1:0]   prod;
    logic signed [PW-1:0]   scaled;
    logic [5:0]             shamt;
    logic                   floor_hit;

    always_comb begin
        mant_s    = {1'b0, frac_gain(att_i[1:0])};
        prod      = PW'(smp_i) * PW'(mant_s);
        shamt     = 6'(GAIN_FRAC) + 6'(att_i[ATT_W-1:2]);
        scaled    = prod >>> shamt;
        floor_hit = (att_i >= FLOOR_C);
    end

    always_ff @(posedge clk) begin
        if (rst)
            smp_o <= '0;
        else
            smp_o <= floor_hit ? '0 : scaled[SMP_W-1:0];
    end

    // R6
    floor_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (att_i == FLOOR_C) |=> (smp_o == '0));

    // R2
    unity_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (att_i == '0) |=> (smp_o == $past(smp_i)));

endmodule

// File: rtl/smute_ctrl.sv
`timescale 1ns/1ps
module smute_ctrl
    import smute_pkg::*;
#(
    parameter int SMP_W         = 16,
    parameter int TICKS_PER_US  = 200,
    parameter int FAST_US       = 1000,
    parameter int SLOW_US       = 35000,
    parameter int STEPS_TO_20DB = 13,
    parameter int FLOOR_CODE    = 40,
    parameter int SYNC_STAGES   = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    mute_req_bit,
    input  logic                    slow_slope_sel,
    input  logic                    mute_pin_n,
    input  logic signed [SMP_W-1:0] smp_in,
    output logic signed [SMP_W-1:0] smp_out,
    output logic [$clog2(FLOOR_CODE+1)-1:0] att_code,
    output logic                    mute_active
);
    localparam int FAST_DIV = step_div(TICKS_PER_US, FAST_US, STEPS_TO_20DB);
    localparam int SLOW_DIV = step_div(TICKS_PER_US, SLOW_US, STEPS_TO_20DB);
    localparam int ATT_W    = $clog2(FLOOR_CODE + 1);
    localparam int CNT_W    = $clog2(SLOW_DIV + 1);

    logic req_q;

    smute_req_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_req (
        .clk    (clk),
        .rst    (rst),
        .reg_req(mute_req_bit),
        .pin_n  (mute_pin_n),
        .req_o  (req_q)
    );

    smute_ramp #(
        .FLOOR_CODE(FLOOR_CODE),
        .FAST_DIV  (FAST_DIV),
        .SLOW_DIV  (SLOW_DIV),
        .ATT_W     (ATT_W),
        .CNT_W     (CNT_W)
    ) u_ramp (
        .clk   (clk),
        .rst   (rst),
        .req_i (req_q),
        .slow_i(slow_slope_sel),
        .att_o (att_code)
    );

    smute_gain #(
        .SMP_W     (SMP_W),
        .ATT_W     (ATT_W),
        .FLOOR_CODE(FLOOR_CODE)
    ) u_gain (
        .clk  (clk),
        .rst  (rst),
        .att_i(att_code),
        .smp_i(smp_in),
        .smp_o(smp_out)
    );

    assign mute_active = req_q | (att_code != '0);

    // R8
    status_release_chk: assert property (@(posedge clk) disable iff (rst)
        (!req_q && mute_active) |-> (att_code != '0));

endmodule

// File: tb/smute_ctrl_tb.sv
`timescale 1ns/1ps
module smute_ctrl_tb;
    localparam int F  = 4;
    localparam int S  = 140;
    localparam int FL = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mute_req_bit = 1'b0;
    logic slow_slope_sel = 1'b0;
    logic mute_pin_n = 1'b1;
    logic signed [15:0] smp_in = '0;
    logic signed [15:0] smp_out;
    logic [5:0] att_code;
    logic mute_active;

    always #2.5 clk = ~clk;

    smute_ctrl #(
        .SMP_W(16), .TICKS_PER_US(1), .FAST_US(52), .SLOW_US(1820),
        .STEPS_TO_20DB(13), .FLOOR_CODE(FL), .SYNC_STAGES(2)
    ) u_dut (
        .clk(clk), .rst(rst), .mute_req_bit(mute_req_bit),
        .slow_slope_sel(slow_slope_sel), .mute_pin_n(mute_pin_n),
        .smp_in(smp_in), .smp_out(smp_out), .att_code(att_code),
        .mute_active(mute_active)
    );

    typedef struct {
        int    cyc;
        int    kind;
        int    exp;
        string tag;
    } item_t;

    item_t sb[$];
    int cyc = 0;
    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string tag, string what, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic expect_at(int c, int kind, int v, string tag);
        item_t it;
        it.cyc = c; it.kind = kind; it.exp = v; it.tag = tag;
        sb.push_back(it);
    endtask

    function automatic int exp_gain(int x, int k);
        int m;
        int p;
        if (k >= FL) return 0;
        m = $rtoi(256.0 * (2.0 ** (-(k % 4) / 4.0)) + 0.5);
        p = x * m;
        return p >>> (8 + k / 4);
    endfunction

    task automatic wait_to(int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic put_sample(int x, int k, string tag);
        smp_in = 16'(x);
        expect_at(cyc + 1, 2, exp_gain(x, k), tag);
    endtask

    // monitor: compares every queued expectation in its due cycle
    always @(negedge clk) begin
        if (!rst) begin
            for (int i = sb.size() - 1; i >= 0; i--) begin
                if (sb[i].cyc == cyc) begin
                    case (sb[i].kind)
                        0:       check(sb[i].tag, "att_code", int'(att_code), sb[i].exp);
                        1:       check(sb[i].tag, "mute_active", int'(mute_active), sb[i].exp);
                        default: check(sb[i].tag, "smp_out", int'(smp_out), sb[i].exp);
                    endcase
                    sb.delete(i);
                end
            end
        end
    end

    initial begin
        int c;
        smp_in = 16'sd5000;
        repeat (4) @(negedge clk);
        // R1 reset state, R11 pin resting high
        check("R1", "att_code", int'(att_code), 0);
        check("R1", "mute_active", int'(mute_active), 0);
        check("R1", "smp_out", int'(smp_out), 0);
        rst = 1'b0;

        // R2 unity pass-through
        put_sample(5000, 0, "R2");
        @(negedge clk);
        put_sample(-1234, 0, "R2");
        expect_at(cyc + 1, 0, 0, "R11");
        expect_at(cyc + 1, 1, 0, "R11");
        repeat (3) @(negedge clk);

        // R3/R4/R8 fast ramp from the register bit
        c = cyc;
        mute_req_bit = 1'b1;
        expect_at(c + 1, 1, 1, "R8");
        for (int k = 1; k <= FL; k++) begin
            expect_at(c + k * F, 0, k - 1, "R4");
            expect_at(c + 1 + k * F, 0, k, "R4");
        end
        wait_to(c + 1 + FL * F + 8);
        put_sample(-32768, FL, "R6");
        expect_at(cyc + 1, 0, FL, "R6");
        @(negedge clk);
        put_sample(32767, FL, "R6");
        repeat (3) @(negedge clk);

        // R7/R8 release, ramp back up at the fast rate
        c = cyc;
        mute_req_bit = 1'b0;
        for (int k = 1; k <= FL; k++) begin
            expect_at(c + k * F, 0, FL - k + 1, "R7");
            expect_at(c + 1 + k * F, 0, FL - k, "R7");
        end
        expect_at(c + FL * F, 1, 1, "R8");
        expect_at(c + 1 + FL * F, 1, 0, "R8");
        wait_to(c + 1 + FL * F + 4);
        put_sample(31000, 0, "R2");
        expect_at(cyc + 1, 1, 0, "R8");

        // R3/R5/R10 slow ramp from the pin
        slow_slope_sel = 1'b1;
        repeat (3) @(negedge clk);
        c = cyc;
        mute_pin_n = 1'b0;
        expect_at(c + 2, 1, 0, "R3");
        expect_at(c + 3, 1, 1, "R3");
        for (int k = 1; k <= FL; k++) begin
            expect_at(c + 2 + k * S, 0, k - 1, "R5");
            expect_at(c + 3 + k * S, 0, k, "R5");
        end
        wait_to(c + 3 + 6 * S + 10);
        put_sample(20000, 6, "R10");
        wait_to(c + 3 + 8 * S + 10);
        put_sample(1000, 8, "R10");
        @(negedge clk);
        put_sample(-777, 8, "R10");
        wait_to(c + 3 + 13 * S + 10);
        put_sample(-777, 13, "R10");
        @(negedge clk);
        put_sample(32767, 13, "R10");
        wait_to(c + 3 + 39 * S + 10);
        put_sample(-32768, 39, "R10");
        wait_to(c + 3 + FL * S + 5);

        // R3/R6 both sources: either one alone keeps the floor
        mute_req_bit = 1'b1;
        slow_slope_sel = 1'b0;
        repeat (3) @(negedge clk);
        c = cyc;
        mute_pin_n = 1'b1;
        expect_at(c + 4, 0, FL, "R3");
        expect_at(c + 20, 0, FL, "R3");
        expect_at(c + 50, 0, FL, "R6");
        expect_at(c + 50, 1, 1, "R8");
        wait_to(c + 60);
        c = cyc;
        mute_req_bit = 1'b0;
        for (int k = 1; k <= FL; k++)
            expect_at(c + 1 + k * F, 0, FL - k, "R7");
        wait_to(c + 1 + FL * F + 4);

        // R9 slope change in mid-step applies from the next step
        c = cyc;
        mute_req_bit = 1'b1;
        expect_at(c + 1 + F, 0, 1, "R9");
        wait_to(c + 2 + F);
        slow_slope_sel = 1'b1;
        expect_at(c + 2 * F, 0, 1, "R9");
        expect_at(c + 1 + 2 * F, 0, 2, "R9");
        expect_at(c + 2 * F + S, 0, 2, "R9");
        expect_at(c + 1 + 2 * F + S, 0, 3, "R9");
        wait_to(c + 3 + 2 * F + S);
        mute_req_bit = 1'b0;
        slow_slope_sel = 1'b0;
        wait_to(cyc + 2 * S);
        expect_at(cyc + 1, 0, 0, "R7");
        expect_at(cyc + 1, 1, 0, "R8");
        @(negedge clk);
        put_sample(-15000, 0, "R11");
        repeat (4) @(negedge clk);

        if (sb.size() != 0) check("R4", "pending expectations", sb.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule